// File: doc/BRIEF.md
# Codec Register Access Controller

This block is the processor-facing front end for reaching the internal registers of an external audio codec. A 32-bit, word-addressed slave port exposes four registers: a control word, the codec register number to access, the word to send to the codec, and the word the codec returned. Software writes the register number and outgoing data, then writes the control word with its request bit set. The block answers with a single-cycle event on one of two interrupt lines. The write flag in the same control word decides which line fires.

The request bit is a trigger and not a state. It is never stored, so reading the control word back always shows it clear, and every other control bit is kept as written. Serial framing toward the codec lives elsewhere. A side port, standing in for the codec's answer, loads the incoming-data register directly and wins over a processor write to that register in the same cycle. Only whole, aligned 32-bit accesses take effect. Read data is registered and appears one cycle after the read is presented.

Top module: `codec_regif`

## Requirements
- R1: Reset clears all four registers, the read data output and both interrupt lines to zero.
- R2: Word index = byte address / 4. Index 0 is control, 1 is codec register number, 2 is outgoing data and 3 is incoming data. A read presented in one cycle returns the value on `rd_data` after the next rising edge. `rd_data` is zero after any cycle that had no accepted read.
- R3: A control write with bit 0 (request) = 1 and bit 1 (write flag) = 1 raises `req_done_irq` for exactly the one cycle that follows the write edge.
- R4: A control write with bit 0 = 1 and bit 1 = 0 raises `reply_irq` for exactly the one cycle that follows the write edge.
- R5: The stored control value is the written value with bit 0 forced to 0. Bits 31..1 read back as written.
- R6: A control write with bit 0 = 0 updates the stored bits and raises neither interrupt line.
- R7: The codec register number, outgoing data and incoming data registers store and return any 32-bit value written to them.
- R8: An access with `bus_strb` other than 4'b1111, or with byte address bits [1:0] not zero, is ignored. It changes no register, and a read of that kind returns zero.
- R9: When `ld_valid` is high, `ld_data` is loaded into the incoming-data register. This takes priority over a processor write to that register in the same cycle.
- R10: An access to a word index of 4 or above changes no register, and a read of it returns zero.
- R11: The two interrupt lines are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_strb | input | DATA_W/8 (4) | Byte strobes; must be all ones |
| bus_wdata | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Registered read data |
| ld_valid | input | 1 | Codec reply strobe |
| ld_data | input | DATA_W (32) | Codec reply word |
| req_done_irq | output | 1 | One-cycle pulse for a write request |
| reply_irq | output | 1 | One-cycle pulse for a read request |

## Verification
The codec reply load and a processor write can land on the incoming-data register in the same cycle. The bench sets up this collision by raising `ld_valid` during the same clock as a bus write to word 3 with a different value. It then reads word 3 back and expects the reply value, not the bus value. A reply load with no bus write, and a bus write with no reply load, are checked next to it, so the priority rule is judged against both single-source outcomes.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;
  localparam int unsigned SLOT_N  = 4;
  localparam int unsigned REQ_BIT = 0;
  localparam int unsigned WR_BIT  = 1;

  typedef enum logic [1:0] {
    SLOT_CTRL  = 2'd0,
    SLOT_CREG  = 2'd1,
    SLOT_TXD   = 2'd2,
    SLOT_RXD   = 2'd3
  } slot_e;
endpackage

// File: rtl/codec_regif_decode.sv
module codec_regif_decode #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned STRB_W = 4,
  parameter int unsigned SLOTS  = 4
) (
  input  logic                       sel,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [STRB_W-1:0]          strb,
  output logic [SLOTS-1:0]           wr_en,
  output logic                       rd_hit,
  output logic [$clog2(SLOTS)-1:0]   rd_idx
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned IDX_W  = $clog2(SLOTS);

  function automatic logic whole_word(input logic [STRB_W-1:0] s, input logic [1:0] lo);
    return (&s) && (lo == 2'b00);
  endfunction

  function automatic logic mapped(input logic [WORD_W-1:0] w);
    return w < WORD_W'(SLOTS);
  endfunction

  logic              accept;
  logic [WORD_W-1:0] word;

  assign word = addr[ADDR_W-1:2];

  always_comb begin
    accept = sel && whole_word(strb, addr[1:0]) && mapped(word);
    wr_en  = '0;
    if (accept && we) wr_en[word[IDX_W-1:0]] = 1'b1;
    rd_hit = accept && !we;
    rd_idx = word[IDX_W-1:0];
  end
endmodule

// File: rtl/codec_regif_ctrl.sv
module codec_regif_ctrl
  import codec_regif_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              req_done_irq,
  output logic              reply_irq
);
  function automatic logic [DATA_W-1:0] strip_trigger(input logic [DATA_W-1:0] d);
    return d & ~(DATA_W'(1) << REQ_BIT);
  endfunction

  logic fire;
  logic is_write;

  assign fire     = wr_en && wdata[REQ_BIT];
  assign is_write = wdata[WR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q       <= '0;
      req_done_irq <= 1'b0;
      reply_irq    <= 1'b0;
    end else begin
      req_done_irq <= fire && is_write;
      reply_irq    <= fire && !is_write;
      if (wr_en) ctrl_q <= strip_trigger(wdata);
    end
  end

  assert_req_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_done_irq |-> $past(wr_en && wdata[REQ_BIT] && wdata[WR_BIT]));

  assert_reply_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reply_irq |-> $past(wr_en && wdata[REQ_BIT] && !wdata[WR_BIT]));

  assert_quiet_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[REQ_BIT]) |=> (!req_done_irq && !reply_irq));
endmodule

// File: rtl/codec_regif_word.sv
module codec_regif_word #(
  parameter int unsigned DATA_W   = 32,
  parameter bit          HAS_LOAD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] ld_data,
  output logic [DATA_W-1:0] q
);
  generate
    if (HAS_LOAD) begin : g_load
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (ld_en)  q <= ld_data;
        else if (wr_en)  q <= wdata;
      end

      assert_side_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (q == $past(ld_data)));

      assert_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ld_en) |=> (q == $past(wdata)));
    end else begin : g_plain
      logic unused_ld;
      assign unused_ld = ld_en ^ (^ld_data);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (wr_en)  q <= wdata;
      end

      assert_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wdata)));
    end
  endgenerate
endmodule

// File: rtl/codec_regif.sv
module codec_regif
  import codec_regif_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W/8-1:0]   bus_strb,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     rd_data,
  input  logic                  ld_valid,
  input  logic [DATA_W-1:0]     ld_data,
  output logic                  req_done_irq,
  output logic                  reply_irq
);
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned IDX_W  = $clog2(SLOT_N);

  logic [SLOT_N-1:0]  wr_en;
  logic               rd_hit;
  logic [IDX_W-1:0]   rd_idx;
  logic [DATA_W-1:0]  word_q [SLOT_N];

  codec_regif_decode #(
    .ADDR_W (ADDR_W),
    .STRB_W (STRB_W),
    .SLOTS  (SLOT_N)
  ) u_decode (
    .sel    (bus_sel),
    .we     (bus_we),
    .addr   (bus_addr),
    .strb   (bus_strb),
    .wr_en  (wr_en),
    .rd_hit (rd_hit),
    .rd_idx (rd_idx)
  );

  codec_regif_ctrl #(
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en[SLOT_CTRL]),
    .wdata        (bus_wdata),
    .ctrl_q       (word_q[SLOT_CTRL]),
    .req_done_irq (req_done_irq),
    .reply_irq    (reply_irq)
  );

  for (genvar g = 1; g < SLOT_N; g++) begin : g_word
    codec_regif_word #(
      .DATA_W   (DATA_W),
      .HAS_LOAD (g == int'(SLOT_RXD))
    ) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en[g]),
      .wdata   (bus_wdata),
      .ld_en   (ld_valid),
      .ld_data (ld_data),
      .q       (word_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_hit) rd_data <= word_q[rd_idx];
    else             rd_data <= '0;
  end

  assert_irq_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_done_irq, reply_irq}));

  assert_ctrl_trigger_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && rd_idx == IDX_W'(SLOT_CTRL)) |=> !rd_data[REQ_BIT]);

  assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !rd_hit) |=> (rd_data == '0));
endmodule

// File: tb/codec_regif_tb.sv
module codec_regif_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_strb = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_data = '0;
  logic        req_done_irq;
  logic        reply_irq;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  codec_regif u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_strb     (bus_strb),
    .bus_wdata    (bus_wdata),
    .rd_data      (rd_data),
    .ld_valid     (ld_valid),
    .ld_data      (ld_data),
    .req_done_irq (req_done_irq),
    .reply_irq    (reply_irq)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [3:0]  strb;
    logic [31:0] data;
    logic [31:0] exp;
    logic        ereq;
    logic        erply;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1, 8'h04, 4'hF, 32'hA5A5_0001, 32'h0,         1'b0, 1'b0, 4'd7},  // R7 write creg
    '{1'b0, 8'h04, 4'hF, 32'h0,         32'hA5A5_0001, 1'b0, 1'b0, 4'd2},  // R2 read creg
    '{1'b1, 8'h08, 4'hF, 32'hDEAD_BEEF, 32'h0,         1'b0, 1'b0, 4'd7},
    '{1'b0, 8'h08, 4'hF, 32'h0,         32'hDEAD_BEEF, 1'b0, 1'b0, 4'd7},
    '{1'b1, 8'h0C, 4'hF, 32'h1234_5678, 32'h0,         1'b0, 1'b0, 4'd7},
    '{1'b0, 8'h0C, 4'hF, 32'h0,         32'h1234_5678, 1'b0, 1'b0, 4'd7},
    '{1'b1, 8'h00, 4'hF, 32'h0000_0003, 32'h0,         1'b1, 1'b0, 4'd3},  // R3 write request
    '{1'b0, 8'h00, 4'hF, 32'h0,         32'h0000_0002, 1'b0, 1'b0, 4'd5},  // R5 bit0 hidden
    '{1'b1, 8'h00, 4'hF, 32'hF0F0_0001, 32'h0,         1'b0, 1'b1, 4'd4},  // R4 read request
    '{1'b0, 8'h00, 4'hF, 32'h0,         32'hF0F0_0000, 1'b0, 1'b0, 4'd5},
    '{1'b1, 8'h00, 4'hF, 32'h8000_0002, 32'h0,         1'b0, 1'b0, 4'd6},  // R6 no trigger
    '{1'b0, 8'h00, 4'hF, 32'h0,         32'h8000_0002, 1'b0, 1'b0, 4'd6},
    '{1'b1, 8'h04, 4'h3, 32'hFFFF_FFFF, 32'h0,         1'b0, 1'b0, 4'd8},  // R8 partial strobe
    '{1'b0, 8'h04, 4'hF, 32'h0,         32'hA5A5_0001, 1'b0, 1'b0, 4'd8},
    '{1'b1, 8'h05, 4'hF, 32'h0,         32'h0,         1'b0, 1'b0, 4'd8},  // R8 misaligned
    '{1'b0, 8'h04, 4'hF, 32'h0,         32'hA5A5_0001, 1'b0, 1'b0, 4'd8},
    '{1'b0, 8'h04, 4'h7, 32'h0,         32'h0,         1'b0, 1'b0, 4'd8},  // R8 partial read
    '{1'b1, 8'h10, 4'hF, 32'h5555_5555, 32'h0,         1'b0, 1'b0, 4'd10}, // R10 unmapped write
    '{1'b0, 8'h10, 4'hF, 32'h0,         32'h0,         1'b0, 1'b0, 4'd10},
    '{1'b0, 8'h00, 4'hF, 32'h0,         32'h8000_0002, 1'b0, 1'b0, 4'd10},
    '{1'b0, 8'h08, 4'hF, 32'h0,         32'hDEAD_BEEF, 1'b0, 1'b0, 4'd10},
    '{1'b1, 8'h00, 4'hF, 32'h0000_0001, 32'h0,         1'b0, 1'b1, 4'd11}  // R11 single line
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // Entered at a falling edge; returns at the falling edge after the access edge.
  task automatic bus_op(input logic wr, input logic [7:0] a, input logic [3:0] s,
                        input logic [31:0] d);
    bus_sel   = 1'b1;
    bus_we    = wr;
    bus_addr  = a[5:0];
    bus_strb  = s;
    bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel   = 1'b0;
    bus_we    = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 req_done_irq in reset", {31'b0, req_done_irq}, 32'h0);
    check("R1 rd_data in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int w = 0; w < 4; w++) begin
      bus_op(1'b0, 8'(w * 4), 4'hF, 32'h0);
      check("R1 word zero after reset", rd_data, 32'h0);
    end

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      string tg;
      bus_op(v.wr, v.addr, v.strb, v.data);
      tg = $sformatf("R%0d vec%0d", v.tag, i);
      check({tg, " rd_data"}, rd_data, v.exp);
      check({tg, " req_done_irq"}, {31'b0, req_done_irq}, {31'b0, v.ereq});
      check({tg, " reply_irq"}, {31'b0, reply_irq}, {31'b0, v.erply});
    end

    // R3 pulse lasts one cycle only
    bus_op(1'b1, 8'h00, 4'hF, 32'h0000_0003);
    check("R3 pulse high", {31'b0, req_done_irq}, 32'h1);
    idle();
    check("R3 pulse gone", {31'b0, req_done_irq}, 32'h0);
    // R4 pulse lasts one cycle only
    bus_op(1'b1, 8'h00, 4'hF, 32'h0000_0001);
    check("R4 pulse high", {31'b0, reply_irq}, 32'h1);
    idle();
    check("R4 pulse gone", {31'b0, reply_irq}, 32'h0);

    // R9 side load alone
    ld_valid = 1'b1;
    ld_data  = 32'hCAFE_0011;
    idle();
    ld_valid = 1'b0;
    bus_op(1'b0, 8'h0C, 4'hF, 32'h0);
    check("R9 side load alone", rd_data, 32'hCAFE_0011);
    // R9 collision: side load and bus write to word 3 in the same cycle
    ld_valid = 1'b1;
    ld_data  = 32'h0BAD_F00D;
    bus_op(1'b1, 8'h0C, 4'hF, 32'h7777_7777);
    ld_valid = 1'b0;
    bus_op(1'b0, 8'h0C, 4'hF, 32'h0);
    check("R9 side load wins", rd_data, 32'h0BAD_F00D);
    // R7 bus write alone still reaches word 3
    bus_op(1'b1, 8'h0C, 4'hF, 32'h7777_7777);
    bus_op(1'b0, 8'h0C, 4'hF, 32'h0);
    check("R7 bus write word 3", rd_data, 32'h7777_7777);
    // R2 idle cycle clears read data
    idle();
    check("R2 rd_data idle zero", rd_data, 32'h0);

    // R1 reset in mid-run
    rst_n = 1'b0;
    idle();
    rst_n = 1'b1;
    @(negedge clk);
    for (int w = 0; w < 4; w++) begin
      bus_op(1'b0, 8'(w * 4), 4'hF, 32'h0);
      check("R1 word cleared by reset", rd_data, 32'h0);
    end

    summary();
    $finish;
  end
endmodule